// File: doc/BRIEF.md
# I2C Receive Double Buffer

This block is the receive-side data path of an I2C peripheral. The bit-level engine delivers each completed byte as a one-cycle strobe, aligned to the rising SCL edge of the ninth clock. The byte lands in a shift-side register. If the host-visible holding register is free, the byte moves there at once and a ready flag goes high. If the holding register still has unread data, the new byte waits in the shift-side register. A host read then releases it. On that read the flag drops and immediately rises again, and the holding register shows the waiting byte.

The block also gates stop-condition interrupts. A mask register, written by the host, decides whether a detected stop in slave mode sets a sticky stop flag and raises the interrupt request. Bit shifting, acknowledge generation, clock stretching and arbitration are handled elsewhere. All updates are synchronous to the system clock.

Top module: `i2c_rx_dbuf`

## Requirements
- R1: After reset, hold_data is 0, data_ready is 0, the stop mask is 0 and stop_irq is 0.
- R2: With enable=1 and tx_mode=0, a byte_done strobe while data_ready=0 puts byte_in on hold_data and sets data_ready, both visible after that clock edge.
- R3: A byte_done strobe while data_ready=1 and no host_rd leaves hold_data unchanged, and data_ready stays 1.
- R4: A host_rd clears data_ready when no byte is waiting. When a byte is waiting, the same edge loads it into hold_data and data_ready reads 1 after that edge.
- R5: When host_rd and byte_done arrive in the same cycle (receive mode, enabled), the read is served first. The new byte goes straight to hold_data and data_ready is 1 after the edge.
- R6: A cycle with enable=0 clears data_ready and discards any waiting byte. After enable returns to 1, a read leaves data_ready 0 and hold_data unchanged.
- R7: While tx_mode=1, no byte moves into hold_data, even on a host_rd. A byte received in transmit mode moves to hold_data on the first edge after tx_mode returns to 0.
- R8: With the mask at 0 and slave_mode=1, a stop_det pulse sets stop_irq (level output) after the edge. A stop_clr pulse clears it.
- R9: With the mask at 1 (written through mask_we/mask_wd), stop_det does not set stop_irq.
- R10: With slave_mode=0, stop_det does not set stop_irq.
- R11: A byte_done strobe that arrives while a byte is already waiting replaces the waiting byte. The next read delivers the newest byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; 0 clears the flag and the waiting byte |
| tx_mode | input | 1 | 1 = transmit mode, which blocks transfers |
| slave_mode | input | 1 | 1 = slave mode with I2C framing |
| byte_done | input | 1 | One-cycle strobe: a received byte is complete |
| byte_in | input | DATA_W | Received byte, valid with byte_done |
| host_rd | input | 1 | One-cycle host read of the holding register |
| stop_det | input | 1 | One-cycle stop-condition pulse |
| stop_clr | input | 1 | Host clear of the stop flag |
| mask_we | input | 1 | Write strobe for the stop mask |
| mask_wd | input | 1 | Stop mask write value |
| hold_data | output | DATA_W | Holding register contents |
| data_ready | output | 1 | Holding register has unread data |
| stop_irq | output | 1 | Gated stop interrupt request |

## Verification
The hardest case to reach is the refill on read. The stimulus must first fill the holding register, then deliver a second byte so that it waits. Only then does a read show the flag dropping and rising on the same edge, with hold_data changing value. The directed tasks build this order explicitly. They extend it by replacing the waiting byte with a third strobe, by making a read coincide with a strobe, and by parking a byte in transmit mode. The parked byte must then surface without any read once receive mode returns.

// File: rtl/i2c_rx_dbuf_pkg.sv
package i2c_rx_dbuf_pkg;
   localparam int unsigned DEF_DATA_W = 8;

   // Variant of the stop interrupt output
   typedef enum logic {
      IRQ_LEVEL = 1'b0,
      IRQ_PULSE = 1'b1
   } irq_kind_e;
endpackage

// File: rtl/rx_shift_stage.sv
module rx_shift_stage #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              byte_done,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              take,
   output logic              src_valid,
   output logic [DATA_W-1:0] src_data
);
   logic [DATA_W-1:0] shift_q;
   logic              pend_q;

   // A fresh byte always wins over an older waiting one
   assign src_valid = enable && (byte_done || pend_q);
   assign src_data  = byte_done ? byte_in : shift_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         pend_q  <= 1'b0;
      end else begin
         if (enable && byte_done)
            shift_q <= byte_in;
         if (!enable)
            pend_q <= 1'b0;
         else
            pend_q <= src_valid && !take;
      end
   end
endmodule

// File: rtl/rx_hold_stage.sv
module rx_hold_stage #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tx_mode,
   input  logic              host_rd,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   output logic              take,
   output logic [DATA_W-1:0] hold_q,
   output logic              rdy_q
);
   logic rdy_after_rd;

   // The read is served first, so a byte may refill on the same edge
   assign rdy_after_rd = rdy_q && !host_rd;
   assign take         = enable && !tx_mode && src_valid && !rdy_after_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         rdy_q  <= 1'b0;
      end else begin
         if (take)
            hold_q <= src_data;
         if (!enable)
            rdy_q <= 1'b0;
         else
            rdy_q <= take ? 1'b1 : rdy_after_rd;
      end
   end
endmodule

// File: rtl/stop_irq_gate.sv
module stop_irq_gate
   import i2c_rx_dbuf_pkg::*;
#(
   parameter irq_kind_e IRQ_KIND = IRQ_LEVEL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slave_mode,
   input  logic stop_det,
   input  logic stop_clr,
   input  logic mask_we,
   input  logic mask_wd,
   output logic mask_q,
   output logic stop_flag,
   output logic irq
);
   logic set_flag;

   assign set_flag = stop_det && slave_mode && !mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q    <= 1'b0;
         stop_flag <= 1'b0;
      end else begin
         if (mask_we)
            mask_q <= mask_wd;
         if (set_flag)
            stop_flag <= 1'b1;
         else if (stop_clr)
            stop_flag <= 1'b0;
      end
   end

   generate
      if (IRQ_KIND == IRQ_LEVEL) begin : g_level
         assign irq = stop_flag;
      end else begin : g_pulse
         logic flag_d;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_d <= 1'b0;
            else        flag_d <= stop_flag;
         end
         assign irq = stop_flag && !flag_d;
      end
   endgenerate
endmodule

// File: rtl/i2c_rx_dbuf.sv
module i2c_rx_dbuf
   import i2c_rx_dbuf_pkg::*;
#(
   parameter int unsigned DATA_W   = DEF_DATA_W,
   parameter irq_kind_e   IRQ_KIND = IRQ_LEVEL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tx_mode,
   input  logic              slave_mode,
   input  logic              byte_done,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              host_rd,
   input  logic              stop_det,
   input  logic              stop_clr,
   input  logic              mask_we,
   input  logic              mask_wd,
   output logic [DATA_W-1:0] hold_data,
   output logic              data_ready,
   output logic              stop_irq
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
   endgenerate

   logic              src_valid;
   logic [DATA_W-1:0] src_data;
   logic              take;
   logic              mask_q;
   logic              stop_flag;

   rx_shift_stage #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .byte_done (byte_done),
      .byte_in   (byte_in),
      .take      (take),
      .src_valid (src_valid),
      .src_data  (src_data)
   );

   rx_hold_stage #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .tx_mode   (tx_mode),
      .host_rd   (host_rd),
      .src_valid (src_valid),
      .src_data  (src_data),
      .take      (take),
      .hold_q    (hold_data),
      .rdy_q     (data_ready)
   );

   stop_irq_gate #(.IRQ_KIND(IRQ_KIND)) u_stop (
      .clk        (clk),
      .rst_n      (rst_n),
      .slave_mode (slave_mode),
      .stop_det   (stop_det),
      .stop_clr   (stop_clr),
      .mask_we    (mask_we),
      .mask_wd    (mask_wd),
      .mask_q     (mask_q),
      .stop_flag  (stop_flag),
      .irq        (stop_irq)
   );
endmodule

// File: rtl/i2c_rx_dbuf_chk.sv
module i2c_rx_dbuf_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              tx_mode,
   input logic              slave_mode,
   input logic              byte_done,
   input logic [DATA_W-1:0] byte_in,
   input logic              host_rd,
   input logic              stop_det,
   input logic              stop_clr,
   input logic [DATA_W-1:0] hold_data,
   input logic              data_ready,
   input logic              mask_q,
   input logic              stop_flag
);
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !tx_mode && byte_done && !data_ready)
      |=> (data_ready && hold_data == $past(byte_in)));

   p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && data_ready && !host_rd && byte_done)
      |=> (data_ready && $stable(hold_data)));

   p_same_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !tx_mode && host_rd && byte_done)
      |=> (data_ready && hold_data == $past(byte_in)));

   p_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !data_ready);

   p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_mode |=> $stable(hold_data));

   p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q && !stop_flag) |=> !stop_flag);

   p_slave_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave_mode && !stop_flag) |=> !stop_flag);

   p_stop_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && slave_mode && !mask_q) |=> stop_flag);
endmodule

bind i2c_rx_dbuf i2c_rx_dbuf_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .tx_mode    (tx_mode),
   .slave_mode (slave_mode),
   .byte_done  (byte_done),
   .byte_in    (byte_in),
   .host_rd    (host_rd),
   .stop_det   (stop_det),
   .stop_clr   (stop_clr),
   .hold_data  (hold_data),
   .data_ready (data_ready),
   .mask_q     (mask_q),
   .stop_flag  (stop_flag)
);

// File: tb/tb_i2c_rx_dbuf.sv
`timescale 1ns/1ps
module tb_i2c_rx_dbuf;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         enable = 1'b0;
   logic         tx_mode = 1'b0;
   logic         slave_mode = 1'b0;
   logic         byte_done = 1'b0;
   logic [W-1:0] byte_in = '0;
   logic         host_rd = 1'b0;
   logic         stop_det = 1'b0;
   logic         stop_clr = 1'b0;
   logic         mask_we = 1'b0;
   logic         mask_wd = 1'b0;
   logic [W-1:0] hold_data;
   logic         data_ready;
   logic         stop_irq;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   i2c_rx_dbuf #(.DATA_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .tx_mode(tx_mode),
      .slave_mode(slave_mode), .byte_done(byte_done), .byte_in(byte_in),
      .host_rd(host_rd), .stop_det(stop_det), .stop_clr(stop_clr),
      .mask_we(mask_we), .mask_wd(mask_wd), .hold_data(hold_data),
      .data_ready(data_ready), .stop_irq(stop_irq)
   );

   task automatic chk(input string req, input logic [W-1:0] act_d,
                      input logic [W-1:0] exp_d, input logic act_r,
                      input logic exp_r);
      checks++;
      if (act_d !== exp_d || act_r !== exp_r) begin
         errors++;
         $display("FAIL %s: hold=%h ready=%b expected hold=%h ready=%b",
                  req, act_d, act_r, exp_d, exp_r);
      end
   endtask

   task automatic chk_irq(input string req, input logic exp);
      checks++;
      if (stop_irq !== exp) begin
         errors++;
         $display("FAIL %s: stop_irq=%b expected %b", req, stop_irq, exp);
      end
   endtask

   // Inputs change on the falling edge; results are sampled on the next falling edge
   task automatic step(input logic bd, input logic [W-1:0] b, input logic rd);
      byte_done = bd; byte_in = b; host_rd = rd;
      @(negedge clk);
      byte_done = 1'b0; host_rd = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", hold_data, 8'h00, data_ready, 1'b0);
      chk_irq("R1", 1'b0);
   endtask

   task automatic t_refill();
      step(1, 8'hA5, 0); chk("R2", hold_data, 8'hA5, data_ready, 1'b1);
      step(1, 8'h3C, 0); chk("R3", hold_data, 8'hA5, data_ready, 1'b1);
      step(0, 8'h00, 1); chk("R4 refill", hold_data, 8'h3C, data_ready, 1'b1);
      step(0, 8'h00, 1); chk("R4 drain", hold_data, 8'h3C, data_ready, 1'b0);
   endtask

   task automatic t_replace();
      step(1, 8'h11, 0);
      step(1, 8'h22, 0);
      step(1, 8'h33, 0); chk("R11 parked", hold_data, 8'h11, data_ready, 1'b1);
      step(0, 8'h00, 1); chk("R11", hold_data, 8'h33, data_ready, 1'b1);
      step(0, 8'h00, 1); chk("R11 drain", hold_data, 8'h33, data_ready, 1'b0);
   endtask

   task automatic t_same_cycle();
      step(1, 8'h44, 0);
      step(1, 8'h55, 1); chk("R5", hold_data, 8'h55, data_ready, 1'b1);
      step(0, 8'h00, 1); chk("R5 drain", hold_data, 8'h55, data_ready, 1'b0);
   endtask

   task automatic t_disable();
      step(1, 8'h66, 0);
      step(1, 8'h77, 0);
      enable = 1'b0;
      step(0, 8'h00, 0); chk("R6 flag", hold_data, 8'h66, data_ready, 1'b0);
      enable = 1'b1;
      step(0, 8'h00, 0); chk("R6 idle", hold_data, 8'h66, data_ready, 1'b0);
      step(0, 8'h00, 1); chk("R6 read", hold_data, 8'h66, data_ready, 1'b0);
   endtask

   task automatic t_tx_mode();
      tx_mode = 1'b1;
      step(1, 8'h88, 0); chk("R7 no load", hold_data, 8'h66, data_ready, 1'b0);
      step(0, 8'h00, 1); chk("R7 read", hold_data, 8'h66, data_ready, 1'b0);
      tx_mode = 1'b0;
      step(0, 8'h00, 0); chk("R7 resume", hold_data, 8'h88, data_ready, 1'b1);
      step(0, 8'h00, 1);
   endtask

   task automatic t_stop();
      slave_mode = 1'b1;
      stop_det = 1'b1; @(negedge clk); stop_det = 1'b0;
      chk_irq("R8 set", 1'b1);
      stop_clr = 1'b1; @(negedge clk); stop_clr = 1'b0;
      chk_irq("R8 clear", 1'b0);
      mask_we = 1'b1; mask_wd = 1'b1; @(negedge clk); mask_we = 1'b0;
      stop_det = 1'b1; @(negedge clk); stop_det = 1'b0;
      chk_irq("R9", 1'b0);
      mask_we = 1'b1; mask_wd = 1'b0; @(negedge clk); mask_we = 1'b0;
      slave_mode = 1'b0;
      stop_det = 1'b1; @(negedge clk); stop_det = 1'b0;
      chk_irq("R10", 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1; enable = 1'b1;
      @(negedge clk);
      t_refill();
      t_replace();
      t_same_cycle();
      t_disable();
      t_tx_mode();
      t_stop();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule